// File: doc/BRIEF.md
# Display Bridge Register Initialization Sequencer

This block programs an external display bridge after reset by driving a byte-write request interface toward a two-wire bus master. A one-cycle pulse on `start_i` begins a run. The sequencer first halts the bridge's internal firmware and then waits a settle time counted in milliseconds. Next it writes the complete configuration register set in a fixed order and restarts the firmware. When the firmware restart has been accepted, it gives a one-cycle `done_o` pulse.

Every register write goes out as two bus requests. The first carries the register index to the command port, and the second carries the value to the data port. The configuration comes in on input ports and is captured when the run starts. It consists of seven power-sequencing delays in milliseconds, a spread-spectrum selection and a lane-swap code. Three of the delays are stored on the bridge in 4 ms units, so the block divides them before writing. The millisecond time base comes from a prescaler, and its ticks-per-millisecond count is a parameter.

Top module: `bridge_init_seq`

## Requirements
- R1: A `start_i` pulse while idle makes the first request a firmware-port write of 0x01 (halt). A `start_i` pulse while busy has no effect on the request stream.
- R2: Port codes are 0 for command, 1 for data and 2 for firmware. A request is held valid, with its port and data unchanged, until the cycle in which `req_ack_i` is high.
- R3: After the halt request is acknowledged, no request appears for at least WAIT_MS × TICKS_PER_MS cycles and at most three cycles more than that.
- R4: Each register write is a command-port request carrying the index, followed directly by a data-port request carrying the value.
- R5: Writes go in this order: indices 0x32–0x38 (delays 1 to 7), then 0x39 and 0x3A (spread spectrum), then 0x3B (lane swap), then the default list, then the firmware restart.
- R6: Delays 2, 5 and 7 are written as the configured value divided by 4, truncated. Delays 1, 3, 4 and 6 are written as given. Only the low 8 bits of each result are written.
- R7: Spread-spectrum selection 0x00 writes 0x20 to index 0x39 and 0x00 to 0x3A. Selections 0x05, 0x10 and 0x15 write 0xA0 to index 0x39 and then 0x07, 0x0F or 0x16 to 0x3A.
- R8: Any other spread-spectrum selection omits both spread-spectrum writes. The rest of the sequence is unchanged.
- R9: Lane-swap code bits [6:0] map 0→0x04, 1→0x14, 2→0x24, 3→0x34 and 4→0x0C, and any other code maps to 0x04. Code bit 7 sets bit 7 of the written value.
- R10: The default list writes 0x06, 0x38, 0x73 and 0x33 to indices 0x3C, 0x3D, 0x3E and 0x3F. It then writes 0x90, 0xB0 and 0x80 to index 0x06, in that order.
- R11: The last request writes 0x00 (run) to the firmware port. In the cycle after it is acknowledged, `done_o` is high for exactly one cycle and `busy_o` is low.
- R12: The configuration inputs are sampled in the start cycle. Changing them during a run does not alter the values written.
- R13: During and right after reset, `req_valid_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a programming run (pulse) |
| dly1_ms_i | input | 16 | Supply-on to link-on delay, ms |
| dly2_ms_i | input | 16 | Link-on to dimming-on delay, ms |
| dly3_ms_i | input | 16 | Dimming-on to backlight-on delay, ms |
| dly4_ms_i | input | 16 | Backlight-off to dimming-off delay, ms |
| dly5_ms_i | input | 16 | Dimming-off to link-off delay, ms |
| dly6_ms_i | input | 16 | Link-off to supply-off delay, ms |
| dly7_ms_i | input | 16 | Minimum gap between power cycles, ms |
| ss_sel_i | input | 8 | Spread-spectrum selection |
| swap_cfg_i | input | 8 | Lane-swap code; bit 7 selects dual-link swap |
| req_valid_o | output | 1 | Byte-write request valid |
| req_port_o | output | 2 | Target port: 0 command, 1 data, 2 firmware |
| req_data_o | output | 8 | Byte to write |
| req_ack_i | input | 1 | Bus master accepts the request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at completion |

## Verification
The bench builds the block with TICKS_PER_MS = 20 and the default WAIT_MS = 60. The 60 ms settle wait then takes 1200 cycles rather than several million. This lets five complete runs fit in the cycle budget, each with a different spread-spectrum selection and lane-swap code. Those runs cover every known selection, an unknown one that triggers the skip, truncation of delays above 255, and an unknown swap code with the dual bit set. The acknowledge is irregular, so requests are often held for several cycles. Spurious starts and configuration changes are injected both during the settle wait and during the register writes.

// File: rtl/bis_pkg.sv
package bis_pkg;

    localparam int unsigned DLY_W      = 16;
    localparam int unsigned DLY_COUNT  = 7;
    localparam int unsigned DEF_COUNT  = 7;
    // delays, two spread-spectrum registers, lane swap, defaults
    localparam int unsigned ENTRY_COUNT = DLY_COUNT + 2 + 1 + DEF_COUNT;
    localparam int unsigned ENTRY_W     = $clog2(ENTRY_COUNT + 1);
    localparam int unsigned SS_FIRST    = DLY_COUNT;
    localparam int unsigned SWAP_SLOT   = DLY_COUNT + 2;
    localparam int unsigned DEF_FIRST   = DLY_COUNT + 3;

    localparam logic [7:0] DLY_BASE_IDX = 8'h32;
    localparam logic [7:0] SS_BASE_IDX  = 8'h39;
    localparam logic [7:0] SWAP_IDX     = 8'h3B;

    // delays held on the bridge in 4 ms units: positions 1, 4, 6 (delays 2, 5, 7)
    localparam logic [DLY_COUNT-1:0] COARSE_MASK = 7'b1010010;

    localparam logic [DEF_COUNT-1:0][7:0] DEF_IDX = '{8'h06, 8'h06, 8'h06, 8'h3F, 8'h3E, 8'h3D, 8'h3C};
    localparam logic [DEF_COUNT-1:0][7:0] DEF_VAL = '{8'h80, 8'hB0, 8'h90, 8'h33, 8'h73, 8'h38, 8'h06};

    localparam logic [7:0] FW_HALT = 8'h01;
    localparam logic [7:0] FW_RUN  = 8'h00;

    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_DATA = 2'd1,
        PORT_FW   = 2'd2
    } port_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_SETTLE,
        ST_PICK,
        ST_INDEX,
        ST_VALUE,
        ST_RUN
    } state_e;

    typedef struct packed {
        logic [DLY_COUNT-1:0][DLY_W-1:0] dly;
        logic [7:0]                      ss_sel;
        logic [7:0]                      swap_cfg;
    } cfg_t;

    typedef struct packed {
        state_e             st;
        logic [ENTRY_W-1:0] idx;
        cfg_t               cfg;
        logic               done;
    } seq_regs_t;

    function automatic logic ss_known(input logic [7:0] sel);
        return (sel == 8'h00) || (sel == 8'h05) || (sel == 8'h10) || (sel == 8'h15);
    endfunction

    function automatic logic [7:0] ss_ctrl_val(input logic [7:0] sel);
        return (sel == 8'h00) ? 8'h20 : 8'hA0;
    endfunction

    function automatic logic [7:0] ss_depth_val(input logic [7:0] sel);
        logic [7:0] v;
        case (sel)
            8'h05:   v = 8'h07;
            8'h10:   v = 8'h0F;
            8'h15:   v = 8'h16;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [7:0] swap_val(input logic [7:0] code);
        logic [7:0] v;
        case (code[6:0])
            7'd1:    v = 8'h14;
            7'd2:    v = 8'h24;
            7'd3:    v = 8'h34;
            7'd4:    v = 8'h0C;
            default: v = 8'h04;
        endcase
        return v | {code[7], 7'b0};
    endfunction

endpackage

// File: rtl/bis_settle_timer.sv
module bis_settle_timer #(
    parameter int unsigned TICKS_PER_MS = 100000,
    parameter int unsigned WAIT_MS      = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int unsigned TICK_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam int unsigned MS_W   = (WAIT_MS > 1) ? $clog2(WAIT_MS) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_MS - 1);
    localparam logic [MS_W-1:0]   MS_LAST   = MS_W'(WAIT_MS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] tick;
        logic [MS_W-1:0]   ms;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic tick_wrap;

    always_comb begin
        cnt_d     = cnt_q;
        tick_wrap = (cnt_q.tick == TICK_LAST);
        expired_o = run_i && tick_wrap && (cnt_q.ms == MS_LAST);
        if (!run_i) begin
            cnt_d = '0;
        end else if (tick_wrap) begin
            cnt_d.tick = '0;
            cnt_d.ms   = cnt_q.ms + 1'b1;
        end else begin
            cnt_d.tick = cnt_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bis_entry_table.sv
module bis_entry_table
    import bis_pkg::*;
(
    input  logic [ENTRY_W-1:0] idx_i,
    input  cfg_t               cfg_i,
    output logic               present_o,
    output logic [7:0]         reg_o,
    output logic [7:0]         val_o
);
    logic [DLY_COUNT-1:0][7:0] dly_reg;
    logic [DLY_COUNT-1:0][7:0] dly_val;

    // one converter per power-sequence delay; the coarse ones drop two bits
    for (genvar k = 0; k < DLY_COUNT; k++) begin : g_dly
        assign dly_reg[k] = DLY_BASE_IDX + 8'(k);
        if (COARSE_MASK[k]) begin : g_coarse
            assign dly_val[k] = 8'(cfg_i.dly[k] >> 2);
        end else begin : g_fine
            assign dly_val[k] = 8'(cfg_i.dly[k]);
        end
    end

    always_comb begin
        int slot;
        slot      = int'(idx_i);
        present_o = 1'b0;
        reg_o     = '0;
        val_o     = '0;
        if (slot < DLY_COUNT) begin
            present_o = 1'b1;
            reg_o     = dly_reg[slot];
            val_o     = dly_val[slot];
        end else if (slot == SS_FIRST) begin
            present_o = ss_known(cfg_i.ss_sel);
            reg_o     = SS_BASE_IDX;
            val_o     = ss_ctrl_val(cfg_i.ss_sel);
        end else if (slot == SS_FIRST + 1) begin
            present_o = ss_known(cfg_i.ss_sel);
            reg_o     = SS_BASE_IDX + 8'd1;
            val_o     = ss_depth_val(cfg_i.ss_sel);
        end else if (slot == SWAP_SLOT) begin
            present_o = 1'b1;
            reg_o     = SWAP_IDX;
            val_o     = swap_val(cfg_i.swap_cfg);
        end else if (slot < ENTRY_COUNT) begin
            present_o = 1'b1;
            reg_o     = DEF_IDX[slot - DEF_FIRST];
            val_o     = DEF_VAL[slot - DEF_FIRST];
        end
    end

endmodule

// File: rtl/bridge_init_seq.sv
module bridge_init_seq
    import bis_pkg::*;
#(
    parameter int unsigned TICKS_PER_MS = 100000,
    parameter int unsigned WAIT_MS      = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DLY_W-1:0] dly1_ms_i,
    input  logic [DLY_W-1:0] dly2_ms_i,
    input  logic [DLY_W-1:0] dly3_ms_i,
    input  logic [DLY_W-1:0] dly4_ms_i,
    input  logic [DLY_W-1:0] dly5_ms_i,
    input  logic [DLY_W-1:0] dly6_ms_i,
    input  logic [DLY_W-1:0] dly7_ms_i,
    input  logic [7:0]       ss_sel_i,
    input  logic [7:0]       swap_cfg_i,
    output logic             req_valid_o,
    output logic [1:0]       req_port_o,
    output logic [7:0]       req_data_o,
    input  logic             req_ack_i,
    output logic             busy_o,
    output logic             done_o
);
    localparam logic [ENTRY_W-1:0] IDX_END = ENTRY_W'(ENTRY_COUNT);

    seq_regs_t  q, d;
    cfg_t       cfg_in;
    logic       settle_done;
    logic       ent_present;
    logic [7:0] ent_reg;
    logic [7:0] ent_val;
    logic       handshake;

    always_comb begin
        cfg_in.dly[0]   = dly1_ms_i;
        cfg_in.dly[1]   = dly2_ms_i;
        cfg_in.dly[2]   = dly3_ms_i;
        cfg_in.dly[3]   = dly4_ms_i;
        cfg_in.dly[4]   = dly5_ms_i;
        cfg_in.dly[5]   = dly6_ms_i;
        cfg_in.dly[6]   = dly7_ms_i;
        cfg_in.ss_sel   = ss_sel_i;
        cfg_in.swap_cfg = swap_cfg_i;
    end

    bis_settle_timer #(
        .TICKS_PER_MS(TICKS_PER_MS),
        .WAIT_MS     (WAIT_MS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (q.st == ST_SETTLE),
        .expired_o(settle_done)
    );

    bis_entry_table u_table (
        .idx_i    (q.idx),
        .cfg_i    (q.cfg),
        .present_o(ent_present),
        .reg_o    (ent_reg),
        .val_o    (ent_val)
    );

    // request outputs are decoded from registered state only
    always_comb begin
        req_valid_o = 1'b0;
        req_port_o  = PORT_CMD;
        req_data_o  = '0;
        case (q.st)
            ST_HALT: begin
                req_valid_o = 1'b1;
                req_port_o  = PORT_FW;
                req_data_o  = FW_HALT;
            end
            ST_INDEX: begin
                req_valid_o = 1'b1;
                req_port_o  = PORT_CMD;
                req_data_o  = ent_reg;
            end
            ST_VALUE: begin
                req_valid_o = 1'b1;
                req_port_o  = PORT_DATA;
                req_data_o  = ent_val;
            end
            ST_RUN: begin
                req_valid_o = 1'b1;
                req_port_o  = PORT_FW;
                req_data_o  = FW_RUN;
            end
            default: ;
        endcase
    end

    assign handshake = req_valid_o && req_ack_i;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st  = ST_HALT;
                    d.cfg = cfg_in;
                    d.idx = '0;
                end
            end
            ST_HALT: begin
                if (handshake) d.st = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (settle_done) d.st = ST_PICK;
            end
            ST_PICK: begin
                if (q.idx == IDX_END) begin
                    d.st = ST_RUN;
                end else if (ent_present) begin
                    d.st = ST_INDEX;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_INDEX: begin
                if (handshake) d.st = ST_VALUE;
            end
            ST_VALUE: begin
                if (handshake) begin
                    d.st  = ST_PICK;
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_RUN: begin
                if (handshake) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: '0, cfg: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != ST_IDLE);
    assign done_o = q.done;

endmodule

// File: rtl/bis_seq_checker.sv
module bis_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       req_valid_o,
    input logic [1:0] req_port_o,
    input logic [7:0] req_data_o,
    input logic       req_ack_i,
    input logic       busy_o,
    input logic       done_o
);
    logic fw_run_taken;
    logic fw_halt_taken;
    assign fw_run_taken  = req_valid_o && req_ack_i && (req_port_o == 2'd2) && (req_data_o == 8'h00);
    assign fw_halt_taken = req_valid_o && req_ack_i && (req_port_o == 2'd2) && (req_data_o == 8'h01);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_port_o) && $stable(req_data_o)));

    p_halt_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (req_valid_o && req_port_o == 2'd2 && req_data_o == 8'h01));

    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !fw_run_taken) |=> busy_o);

    p_settle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fw_halt_taken |=> !req_valid_o);

    p_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ack_i && req_port_o == 2'd0) |=> (req_valid_o && req_port_o == 2'd1));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(fw_run_taken) && !busy_o));

    p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !req_valid_o);

endmodule

bind bridge_init_seq bis_seq_checker u_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .req_valid_o(req_valid_o),
    .req_port_o (req_port_o),
    .req_data_o (req_data_o),
    .req_ack_i  (req_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o)
);

// File: tb/test_bridge_init_seq.sv
`timescale 1ns/1ps
module test_bridge_init_seq;
    localparam int TPM      = 20;
    localparam int WMS      = 60;
    localparam int SETTLE   = TPM * WMS;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] d1 = '0, d2 = '0, d3 = '0, d4 = '0, d5 = '0, d6 = '0, d7 = '0;
    logic [7:0]  ss_sel = '0, swap_cfg = '0;
    logic        req_valid_o;
    logic [1:0]  req_port_o;
    logic [7:0]  req_data_o;
    logic        req_ack_i = 1'b0;
    logic        busy_o, done_o;

    always #5 clk = ~clk;

    bridge_init_seq #(.TICKS_PER_MS(TPM), .WAIT_MS(WMS)) i_bridge_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dly1_ms_i(d1), .dly2_ms_i(d2), .dly3_ms_i(d3), .dly4_ms_i(d4),
        .dly5_ms_i(d5), .dly6_ms_i(d6), .dly7_ms_i(d7),
        .ss_sel_i(ss_sel), .swap_cfg_i(swap_cfg),
        .req_valid_o(req_valid_o), .req_port_o(req_port_o), .req_data_o(req_data_o),
        .req_ack_i(req_ack_i), .busy_o(busy_o), .done_o(done_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    exp_port[$];
    int    exp_data[$];
    string exp_tag[$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    task automatic push(input int port, input int data, input string tag);
        exp_port.push_back(port);
        exp_data.push_back(data);
        exp_tag.push_back(tag);
    endtask

    task automatic push_reg(input int idx, input int val, input string tag);
        push(0, idx, "R5");
        push(1, val, tag);
    endtask

    function automatic int swap_expect(input int code);
        int base;
        case (code & 8'h7F)
            1: base = 8'h14;
            2: base = 8'h24;
            3: base = 8'h34;
            4: base = 8'h0C;
            default: base = 8'h04;
        endcase
        if ((code & 8'h80) != 0) base = base | 8'h80;
        return base;
    endfunction

    // reference sequence built from the requirements
    task automatic build(input int t1, input int t2, input int t3, input int t4,
                         input int t5, input int t6, input int t7, input int ss, input int sw);
        push(2, 8'h01, "R1");
        push_reg(8'h32, t1 & 8'hFF, "R6");
        push_reg(8'h33, (t2 / 4) & 8'hFF, "R6");
        push_reg(8'h34, t3 & 8'hFF, "R6");
        push_reg(8'h35, t4 & 8'hFF, "R6");
        push_reg(8'h36, (t5 / 4) & 8'hFF, "R6");
        push_reg(8'h37, t6 & 8'hFF, "R6");
        push_reg(8'h38, (t7 / 4) & 8'hFF, "R6");
        case (ss)
            8'h00: begin push_reg(8'h39, 8'h20, "R7"); push_reg(8'h3A, 8'h00, "R7"); end
            8'h05: begin push_reg(8'h39, 8'hA0, "R7"); push_reg(8'h3A, 8'h07, "R7"); end
            8'h10: begin push_reg(8'h39, 8'hA0, "R7"); push_reg(8'h3A, 8'h0F, "R7"); end
            8'h15: begin push_reg(8'h39, 8'hA0, "R7"); push_reg(8'h3A, 8'h16, "R7"); end
            default: ; // R8: both spread-spectrum writes are left out
        endcase
        push_reg(8'h3B, swap_expect(sw), "R9");
        push_reg(8'h3C, 8'h06, "R10");
        push_reg(8'h3D, 8'h38, "R10");
        push_reg(8'h3E, 8'h73, "R10");
        push_reg(8'h3F, 8'h33, "R10");
        push_reg(8'h06, 8'h90, "R10");
        push_reg(8'h06, 8'hB0, "R10");
        push_reg(8'h06, 8'h80, "R10");
        push(2, 8'h00, "R11");
    endtask

    // monitor: compares the bus on every cycle, away from the active edge
    logic [15:0] lfsr = 16'hACE1;
    bit   prev_hold = 0;
    int   prev_port, prev_data;
    bit   gap_active = 0;
    int   gap = 0;
    bit   done_due = 0;
    bit   run_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (done_due) begin
                chk(done_o === 1'b1, "R11", "done pulse after run write", done_o, 1);
                chk(busy_o === 1'b0, "R11", "busy after done", busy_o, 0);
                done_due = 0;
                run_done = 1;
            end else if (done_o !== 1'b0) begin
                chk(1'b0, "R11", "done outside expected cycle", done_o, 0);
            end
            if (req_valid_o) begin
                if (prev_hold) begin
                    chk(req_port_o == prev_port[1:0] && req_data_o == prev_data[7:0], "R2",
                        "request changed before ack", {req_port_o, req_data_o}, {prev_port[1:0], prev_data[7:0]});
                end
                if (gap_active) begin
                    chk(gap >= SETTLE && gap <= SETTLE + 3, "R3", "settle gap cycles", gap, SETTLE);
                    gap_active = 0;
                end
                if (exp_port.size() == 0) begin
                    chk(1'b0, "R12", "unexpected request", {req_port_o, req_data_o}, 0);
                    req_ack_i = 1'b1;
                end else begin
                    chk(req_port_o == exp_port[0][1:0] && req_data_o == exp_data[0][7:0], exp_tag[0],
                        "port/data", {req_port_o, req_data_o}, {exp_port[0][1:0], exp_data[0][7:0]});
                    req_ack_i = lfsr[0] | lfsr[1];
                    if (req_ack_i) begin
                        if (exp_port[0] == 2 && exp_data[0] == 1) begin
                            gap_active = 1;
                            gap = 0;
                        end
                        void'(exp_port.pop_front());
                        void'(exp_data.pop_front());
                        void'(exp_tag.pop_front());
                        if (exp_port.size() == 0) done_due = 1;
                    end
                end
                prev_hold = !req_ack_i;
                prev_port = int'(req_port_o);
                prev_data = int'(req_data_o);
            end else begin
                if (prev_hold) chk(1'b0, "R2", "request dropped before ack", 0, 1);
                prev_hold = 0;
                req_ack_i = 1'b0;
                if (gap_active) gap++;
            end
        end
    end

    // watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL R11 watchdog: actual cycles %0d expected completion below %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic run_case(input int t1, input int t2, input int t3, input int t4,
                            input int t5, input int t6, input int t7, input int ss, input int sw);
        build(t1, t2, t3, t4, t5, t6, t7, ss, sw);
        run_done = 0;
        @(negedge clk);
        d1 = 16'(t1); d2 = 16'(t2); d3 = 16'(t3); d4 = 16'(t4);
        d5 = 16'(t5); d6 = 16'(t6); d7 = 16'(t7);
        ss_sel = 8'(ss); swap_cfg = 8'(sw);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R12: disturb the inputs while busy; R1: spurious start during settle
        d1 = 16'hFFFF; d2 = 16'h1234; ss_sel = 8'h33; swap_cfg = 8'h02;
        repeat (30) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (SETTLE + 20) @(negedge clk);
        // R1: spurious start during the register writes
        d5 = 16'h00FF; d7 = 16'h0400;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!run_done) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(exp_port.size() == 0, "R5", "expected writes left over", exp_port.size(), 0);
        chk(busy_o === 1'b0, "R11", "busy after run", busy_o, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_valid_o === 1'b0, "R13", "valid in reset", req_valid_o, 0);
        chk(busy_o === 1'b0, "R13", "busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o === 1'b0, "R13", "done after reset", done_o, 0);
        chk(req_valid_o === 1'b0, "R13", "valid after reset", req_valid_o, 0);

        run_case(10, 20, 5, 7, 50, 3, 400, 8'h10, 8'h81);
        run_case(300, 1023, 0, 255, 3, 513, 2, 8'h00, 8'h04);
        run_case(1, 4, 9, 16, 8, 2, 60, 8'h33, 8'h87);
        run_case(0, 7, 255, 1, 40, 80, 1020, 8'h05, 8'h02);
        run_case(65535, 65535, 12, 13, 12, 14, 5, 8'h15, 8'h83);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule